// File: doc/BRIEF.md
# Reduced-Modulus Binary Counter

This block is a small binary counter whose natural range of 2^WIDTH states is cut down to a chosen modulus K. A decoder watches the count register and, when it sees a terminal code, drives the counter's reset. The decoder examines only the bit positions that are one in that terminal code. Because of this, it stays cheap and it never matches an earlier state of the shortened sequence. The block serves both as a modulo-K event counter and as a divide-by-K frequency divider, where the wrap pulse is the divided output.

A parameter selects how the decoder feeds the reset. In the immediate (master) style, the decoder looks for code K. That code appears for one internal cycle only, and it is cleared before the next count is accepted, so an enable that arrives during it is still counted. In the synchronous style, the decoder looks for code K-1, and the next enable loads zero directly. The outputs are registered, and both styles show the same sequence at the ports: 0, 1, …, K-1, 0. A one-cycle wrap pulse accompanies each return to zero.

Top module: `modk_counter`

## Requirements
- R1: One cycle after `rst` is sampled high, `count_o` is 0 and `wrap_o` is 0.
- R2: A cycle in which `en` is sampled low leaves `count_o` unchanged and gives `wrap_o` = 0 in the following cycle.
- R3: When `en` is sampled high and `count_o` is below K-1, `count_o` becomes its old value plus one at that edge, and `wrap_o` is 0.
- R4: When `en` is sampled high and `count_o` equals K-1, `count_o` becomes 0 and `wrap_o` is 1 for exactly that one cycle.
- R5: `count_o` never shows a value of K or above, in either reset style. The transient terminal state of the immediate style is never visible.
- R6: `wrap_o` is high only in the cycle after an edge at which `en` was high and `count_o` was K-1.
- R7: Both reset styles produce identical `count_o` and `wrap_o` sequences for identical stimulus, including enables on consecutive cycles across a wrap.
- R8: `rst` takes priority over `en`. A reset sampled together with an enable still yields count 0 and no wrap pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Count enable, one count per sampled high |
| count_o | output | WIDTH | Registered count, 0 to K-1 |
| wrap_o | output | 1 | One-cycle pulse on the return to 0 |

## Verification
The bound checker checks the following on every cycle: the count stays below K; each enable either increments the count or wraps it; an idle cycle holds the count; and the wrap pulse follows only an enabled edge at K-1. Some behaviours can only be shown by the bench's scenarios. These are that both reset styles give the same visible sequence when run side by side; that the enable arriving during the immediate style's transient state is not lost; and that reset wins when it coincides with an enable.

// File: rtl/modk_pkg.sv
package modk_pkg;
  typedef enum logic {
    RST_MASTER = 1'b0,
    RST_SYNC   = 1'b1
  } rst_style_e;
endpackage

// File: rtl/modk_detector.sv
// Terminal-code decoder: ANDs only the bits that are one in TARGET.
module modk_detector #(
  parameter int                 WIDTH  = 4,
  parameter logic [WIDTH-1:0]   TARGET = '0
) (
  input  logic [WIDTH-1:0] state_i,
  output logic             hit_o
);
  logic [WIDTH-1:0] term;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    if (TARGET[b]) begin : g_use
      assign term[b] = state_i[b];
    end else begin : g_skip
      assign term[b] = 1'b1;
    end
  end

  assign hit_o = &term;
endmodule

// File: rtl/modk_step.sv
// Next-state logic; the reset style picks which code is decoded.
module modk_step
  import modk_pkg::*;
#(
  parameter int         WIDTH   = 4,
  parameter int         MODULUS = 13,
  parameter rst_style_e STYLE   = RST_MASTER
) (
  input  logic [WIDTH-1:0] state_i,
  input  logic             en_i,
  output logic [WIDTH-1:0] state_d_o,
  output logic [WIDTH-1:0] count_d_o,
  output logic             wrap_d_o
);
  localparam logic [WIDTH-1:0] MOD_CODE  = WIDTH'(MODULUS);
  localparam logic [WIDTH-1:0] LAST_CODE = WIDTH'(MODULUS - 1);
  localparam logic [WIDTH-1:0] ONE       = WIDTH'(1);

  if (STYLE == RST_SYNC) begin : g_sync
    logic at_last;

    modk_detector #(.WIDTH(WIDTH), .TARGET(LAST_CODE)) u_det_last (
      .state_i (state_i),
      .hit_o   (at_last)
    );

    always_comb begin
      state_d_o = state_i;
      wrap_d_o  = 1'b0;
      if (en_i) begin
        if (at_last) begin
          state_d_o = '0;
          wrap_d_o  = 1'b1;
        end else begin
          state_d_o = state_i + ONE;
        end
      end
      count_d_o = state_d_o;
    end
  end else begin : g_master
    logic             in_term;
    logic             to_term;
    logic [WIDTH-1:0] cleared;
    logic [WIDTH-1:0] nxt;

    // Current state K acts as a reset that takes effect before counting.
    modk_detector #(.WIDTH(WIDTH), .TARGET(MOD_CODE)) u_det_cur (
      .state_i (state_i),
      .hit_o   (in_term)
    );

    assign cleared = in_term ? '0 : state_i;
    assign nxt     = en_i ? cleared + ONE : cleared;

    // Look ahead so the transient code never reaches the output register.
    modk_detector #(.WIDTH(WIDTH), .TARGET(MOD_CODE)) u_det_nxt (
      .state_i (nxt),
      .hit_o   (to_term)
    );

    always_comb begin
      state_d_o = nxt;
      count_d_o = to_term ? '0 : nxt;
      wrap_d_o  = en_i & to_term;
    end
  end
endmodule

// File: rtl/modk_counter.sv
module modk_counter
  import modk_pkg::*;
#(
  parameter int         WIDTH   = 4,
  parameter int         MODULUS = 13,
  parameter rst_style_e STYLE   = RST_MASTER
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [WIDTH-1:0] count_o,
  output logic             wrap_o
);
  if (MODULUS < 1 || MODULUS >= (1 << WIDTH)) begin : g_bad_mod
    $error("modk_counter: MODULUS out of range");
  end

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;
  logic [WIDTH-1:0] count_d;
  logic             wrap_d;

  modk_step #(.WIDTH(WIDTH), .MODULUS(MODULUS), .STYLE(STYLE)) u_step (
    .state_i   (state_q),
    .en_i      (en),
    .state_d_o (state_d),
    .count_d_o (count_d),
    .wrap_d_o  (wrap_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
      count_o <= '0;
      wrap_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      count_o <= count_d;
      wrap_o  <= wrap_d;
    end
  end
endmodule

// File: rtl/modk_counter_chk.sv
module modk_counter_chk #(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [WIDTH-1:0] count_o,
  input logic             wrap_o
);
  localparam logic [WIDTH:0]   K_WIDE = (WIDTH+1)'(MODULUS);
  localparam logic [WIDTH-1:0] LAST   = WIDTH'(MODULUS - 1);

  logic rst_seen = 1'b0;
  always_ff @(posedge clk) rst_seen <= rst;

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    rst_seen |-> (count_o == '0 && !wrap_o));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(count_o) && !wrap_o));

  assert_increment_R3: assert property (@(posedge clk) disable iff (rst)
    (en && count_o != LAST) |=> (count_o == $past(count_o) + 1'b1 && !wrap_o));

  assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (en && count_o == LAST) |=> (count_o == '0 && wrap_o));

  assert_below_modulus_R5: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, count_o} < K_WIDE));

  assert_wrap_cause_R6: assert property (@(posedge clk) disable iff (rst)
    wrap_o |-> ($past(en) && $past(count_o) == LAST));
endmodule

bind modk_counter modk_counter_chk #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (en),
  .count_o (count_o),
  .wrap_o  (wrap_o)
);

// File: tb/modk_counter_bench.sv
module modk_counter_bench;
  import modk_pkg::*;

  localparam int WIDTH = 4;
  localparam int K     = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [WIDTH-1:0] cnt_m, cnt_s;
  logic             wrp_m, wrp_s;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;
  bit exp_wrap = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  modk_counter #(.WIDTH(WIDTH), .MODULUS(K), .STYLE(RST_MASTER)) u_modk_counter (
    .clk(clk), .rst(rst), .en(en), .count_o(cnt_m), .wrap_o(wrp_m)
  );

  modk_counter #(.WIDTH(WIDTH), .MODULUS(K), .STYLE(RST_SYNC)) u_modk_counter_sync (
    .clk(clk), .rst(rst), .en(en), .count_o(cnt_s), .wrap_o(wrp_s)
  );

  // Stimulus {rst, en}
  localparam logic [1:0] STIM [0:23] = '{
    2'b10, 2'b01, 2'b01, 2'b00, 2'b01, 2'b00, 2'b00, 2'b01,
    2'b01, 2'b01, 2'b11, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01,
    2'b00, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01
  };

  task automatic check(input bit c, input string req, input int act, input int exp);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock with the given inputs, then compare both instances.
  task automatic step(input bit r, input bit e);
    string tag;
    rst = r;
    en  = e;
    if (r) begin
      exp_cnt = 0; exp_wrap = 1'b0; tag = e ? "R8" : "R1";
    end else if (e) begin
      exp_wrap = (exp_cnt == K - 1);
      exp_cnt  = exp_wrap ? 0 : exp_cnt + 1;
      tag = exp_wrap ? "R4" : "R3";
    end else begin
      exp_wrap = 1'b0; tag = "R2";
    end
    @(posedge clk);
    #2;
    check(int'(cnt_m) == exp_cnt, {tag, " count master"}, int'(cnt_m), exp_cnt);
    check(wrp_m == exp_wrap, {tag, " wrap master"}, int'(wrp_m), int'(exp_wrap));
    check(int'(cnt_s) == exp_cnt, {tag, " count sync"}, int'(cnt_s), exp_cnt);
    check(wrp_s == exp_wrap, {tag, " wrap sync"}, int'(wrp_s), int'(exp_wrap));
    check(int'(cnt_m) < K && int'(cnt_s) < K, "R5 count below K", int'(cnt_m), K - 1);
    check(cnt_m == cnt_s && wrp_m == wrp_s, "R7 styles agree", int'(cnt_m), int'(cnt_s));
  endtask

  initial begin
    #2;
    for (int i = 0; i < 24; i++) step(STIM[i][1], STIM[i][0]);
    // Directed: run to K-1 and idle there (R2), then wrap (R4)
    step(1'b1, 1'b0);
    for (int i = 0; i < K - 1; i++) step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    // Back-to-back enables through two wraps: no lost count after wrap (R7)
    for (int i = 0; i < 2 * K + 3; i++) step(1'b0, 1'b1);
    // Reset coinciding with the wrapping enable (R8)
    while (exp_cnt != K - 1) step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    // Alternating enable pattern across a wrap
    for (int i = 0; i < 2 * K + 4; i++) step(1'b0, i[0]);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule